// File: doc/BRIEF.md
# Interrupt Status Aggregator with Coalescing

This block collects interrupt causes from a network controller datapath into a 32-bit status register. It ANDs the status with a 32-bit enable mask and drives one interrupt request line to the host. Each cycle the datapath can present a post vector, which sets status bits, and a clear vector, which removes them. Only eight cause bits exist in hardware. Any other bit in either vector is dropped without effect. Bit 31 is reserved, and touching it raises an error pulse.

Enabled causes fall into two classes. Routine completion causes are receive OK, receive descriptor, transmit OK and transmit descriptor. They are coalesced: the request rises only after a programmable number of clock cycles. Every other enabled cause is urgent and raises the request at once. The request line is itself the pending flag. It stays high while any enabled cause remains, and it drops once the enabled status is empty.

All pins are plain level-sampled control and status signals. The vectors are single-cycle pulses that the block samples every cycle, so there is no valid/ready handshake and no back-pressure. A zero vector means "no event".

Top module: `irq_coalesce_top`

## Requirements
- R1: While `rst_n` is low at a clock edge, the status, mask, delay counter, request and error output all become zero.
- R2: A post vector ORs into the status register. Only the implemented cause positions are stored: bit 0 receive OK, bit 1 receive descriptor, bit 3 software, bit 4 receive overrun, bit 5 receive idle, bit 6 transmit OK, bit 7 transmit descriptor and bit 16 transmit idle. This is the set 0x000100FB. All other post bits are discarded.
- R3: A clear vector removes its implemented bits from the status register (AND-NOT). When a post and a clear arrive in the same cycle, the clear is applied first and the post second, so a bit present in both ends up set.
- R4: Status bit 31 is never set, and a clear vector with bit 31 set changes no status bit.
- R5: `rsvd_err_o` is high for the cycle after a post or clear vector carries bit 31, and low otherwise.
- R6: A request is scheduled only when (status AND mask) is nonzero. A pending cause whose mask bit is 0 never raises `irq_o`.
- R7: If an enabled pending bit lies outside the delayable set 0x000000C3, `irq_o` rises one cycle after the status register shows that bit. That is two clock edges after the post.
- R8: If every enabled pending bit is delayable, `irq_o` rises `delay_cfg` cycles later than it would for an urgent cause. With `delay_cfg` = 0 the timing is identical to R7.
- R9: An urgent cause that becomes enabled while the coalescing count is running cancels the count, and `irq_o` rises in the next cycle.
- R10: While `irq_o` is high and the enabled status is nonzero, `irq_o` stays high. Further posts have no effect on it.
- R11: When the enabled status becomes zero, by clearing or by masking, `irq_o` falls on the next edge and the delay counter returns to zero. A later delayable cause then waits the full delay again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| post_vec | input | 32 | Causes to set this cycle |
| clr_vec | input | 32 | Causes to clear this cycle |
| mask_we | input | 1 | Load `mask_wdata` into the mask register |
| mask_wdata | input | 32 | New enable mask |
| delay_cfg | input | DLY_W (16) | Coalescing delay in clock cycles |
| status_o | output | 32 | Current status register |
| irq_o | output | 1 | Host interrupt request (pending flag) |
| rsvd_err_o | output | 1 | Reserved-bit access seen in the previous cycle |

## Verification
Two pairs of functions can fall in the same cycle. The first pair is a post and a clear of the same bit. The bench drives both vectors in one cycle and expects the bit to be set afterwards. The second pair is a running coalescing count and an arriving urgent cause. The bench posts a delayable cause, lets the count advance a few cycles, then posts a receive-overrun cause. It expects the request two edges later, well before the programmed delay would expire. Exact edge counts are also checked for the delayed path, both after a fresh start and after an aborted count.

// File: rtl/irq_coal_pkg.sv
package irq_coal_pkg;
  localparam int unsigned VEC_W = 32;
  localparam int unsigned RSVD_POS = 31;

  // cause positions
  localparam int unsigned C_RX_OK    = 0;
  localparam int unsigned C_RX_DESC  = 1;
  localparam int unsigned C_SOFT     = 3;
  localparam int unsigned C_RX_ORUN  = 4;
  localparam int unsigned C_RX_IDLE  = 5;
  localparam int unsigned C_TX_OK    = 6;
  localparam int unsigned C_TX_DESC  = 7;
  localparam int unsigned C_TX_IDLE  = 16;

  localparam logic [VEC_W-1:0] LIVE_SET =
      (VEC_W'(1) << C_RX_OK)   | (VEC_W'(1) << C_RX_DESC) |
      (VEC_W'(1) << C_SOFT)    | (VEC_W'(1) << C_RX_ORUN) |
      (VEC_W'(1) << C_RX_IDLE) | (VEC_W'(1) << C_TX_OK)   |
      (VEC_W'(1) << C_TX_DESC) | (VEC_W'(1) << C_TX_IDLE);

  localparam logic [VEC_W-1:0] LAZY_SET =
      (VEC_W'(1) << C_RX_OK) | (VEC_W'(1) << C_RX_DESC) |
      (VEC_W'(1) << C_TX_OK) | (VEC_W'(1) << C_TX_DESC);

  typedef struct packed {
    logic any_on;
    logic urgent_on;
  } cls_t;
endpackage

// File: rtl/irq_status_bank.sv
module irq_status_bank
  import irq_coal_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic [VEC_W-1:0] post_vec,
  input  logic [VEC_W-1:0] clr_vec,
  input  logic             mask_we,
  input  logic [VEC_W-1:0] mask_wdata,
  output logic [VEC_W-1:0] status_q,
  output logic [VEC_W-1:0] mask_q,
  output logic             err_q
);
  logic [VEC_W-1:0] set_eff;
  logic [VEC_W-1:0] drop_eff;
  logic [VEC_W-1:0] status_d;

  // reserved and unimplemented positions are stripped before any update
  always_comb begin
    set_eff  = post_vec & LIVE_SET;
    drop_eff = clr_vec & LIVE_SET;
    status_d = (status_q & ~drop_eff) | set_eff;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      status_q <= '0;
      mask_q   <= '0;
      err_q    <= 1'b0;
    end else begin
      status_q <= status_d;
      if (mask_we) mask_q <= mask_wdata & LIVE_SET;
      err_q    <= post_vec[RSVD_POS] | clr_vec[RSVD_POS];
    end
  end
endmodule

// File: rtl/irq_classify.sv
module irq_classify
  import irq_coal_pkg::*;
(
  input  logic [VEC_W-1:0] status_q,
  input  logic [VEC_W-1:0] mask_q,
  output cls_t             cls
);
  logic [VEC_W-1:0] en_bits;
  logic [VEC_W-1:0] hot_bits;

  for (genvar b = 0; b < VEC_W; b++) begin : g_bit
    assign en_bits[b]  = status_q[b] & mask_q[b];
    assign hot_bits[b] = en_bits[b] & ~LAZY_SET[b];
  end

  assign cls.any_on    = |en_bits;
  assign cls.urgent_on = |hot_bits;
endmodule

// File: rtl/irq_coalesce_timer.sv
module irq_coalesce_timer #(
  parameter int unsigned DLY_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  irq_coal_pkg::cls_t cls,
  input  logic [DLY_W-1:0] delay_cfg,
  output logic [DLY_W-1:0] cnt_q,
  output logic             pend_q
);
  logic fire;
  assign fire = cls.urgent_on || (cnt_q >= delay_cfg);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pend_q <= 1'b0;
      cnt_q  <= '0;
    end else if (!cls.any_on) begin
      pend_q <= 1'b0;
      cnt_q  <= '0;
    end else if (pend_q) begin
      pend_q <= 1'b1;
      cnt_q  <= '0;
    end else if (fire) begin
      pend_q <= 1'b1;
      cnt_q  <= '0;
    end else begin
      cnt_q  <= cnt_q + 1'b1;
    end
  end
endmodule

// File: rtl/irq_coalesce_top.sv
module irq_coalesce_top
  import irq_coal_pkg::*;
#(
  parameter int unsigned DLY_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [31:0]      post_vec,
  input  logic [31:0]      clr_vec,
  input  logic             mask_we,
  input  logic [31:0]      mask_wdata,
  input  logic [DLY_W-1:0] delay_cfg,
  output logic [31:0]      status_o,
  output logic             irq_o,
  output logic             rsvd_err_o
);
  logic [VEC_W-1:0] status_q;
  logic [VEC_W-1:0] mask_q;
  logic             err_q;
  cls_t             cls;
  logic [DLY_W-1:0] dly_cnt;
  logic             pend_q;

  irq_status_bank u_bank (
    .clk       (clk),
    .rst_n     (rst_n),
    .post_vec  (post_vec),
    .clr_vec   (clr_vec),
    .mask_we   (mask_we),
    .mask_wdata(mask_wdata),
    .status_q  (status_q),
    .mask_q    (mask_q),
    .err_q     (err_q)
  );

  irq_classify u_cls (
    .status_q(status_q),
    .mask_q  (mask_q),
    .cls     (cls)
  );

  irq_coalesce_timer #(.DLY_W(DLY_W)) u_tmr (
    .clk      (clk),
    .rst_n    (rst_n),
    .cls      (cls),
    .delay_cfg(delay_cfg),
    .cnt_q    (dly_cnt),
    .pend_q   (pend_q)
  );

  assign status_o   = status_q;
  assign irq_o      = pend_q;
  assign rsvd_err_o = err_q;
endmodule

// File: rtl/irq_coalesce_chk.sv
module irq_coalesce_chk #(
  parameter int unsigned DLY_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic [31:0]      post_vec,
  input logic [31:0]      clr_vec,
  input logic [31:0]      status_o,
  input logic [31:0]      mask_q,
  input logic             irq_o,
  input logic             rsvd_err_o,
  input logic [DLY_W-1:0] dly_cnt
);
  logic [31:0] en_w;
  assign en_w = status_o & mask_q;

  AST_RSVD_NEVER_SET: assert property (@(posedge clk) disable iff (!rst_n)
    !status_o[31]); // R4

  AST_ONLY_LIVE_BITS: assert property (@(posedge clk) disable iff (!rst_n)
    (status_o & ~32'h000100FB) == 32'h0); // R2

  AST_ERR_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    (post_vec[31] || clr_vec[31]) |=> rsvd_err_o); // R5

  AST_URGENT_NEXT: assert property (@(posedge clk) disable iff (!rst_n)
    ((en_w & ~32'h000000C3) != 32'h0) |=> irq_o); // R7

  AST_HOLD_PENDING: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_o && en_w != 32'h0) |=> irq_o); // R10

  AST_DROP_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
    (en_w == 32'h0) |=> (!irq_o && dly_cnt == '0)); // R11

  AST_NO_SPURIOUS: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq_o) |-> $past(en_w) != 32'h0); // R6
endmodule

bind irq_coalesce_top irq_coalesce_chk #(.DLY_W(DLY_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .post_vec  (post_vec),
  .clr_vec   (clr_vec),
  .status_o  (status_o),
  .mask_q    (mask_q),
  .irq_o     (irq_o),
  .rsvd_err_o(rsvd_err_o),
  .dly_cnt   (dly_cnt)
);

// File: tb/irq_coalesce_top_tb_top.sv
`timescale 1ns/1ps
module irq_coalesce_top_tb_top;
  localparam int DLY_W = 16;
  localparam int NV = 9;

  // walked table: post, clear, expected status, expected error (mask stays 0)
  localparam logic [31:0] T_POST [NV] = '{32'h1, 32'hFFFFFFFF, 32'h0, 32'h3,
    32'h0, 32'h00010008, 32'h80000100, 32'h0, 32'h40};
  localparam logic [31:0] T_CLR  [NV] = '{32'h0, 32'h0, 32'h3, 32'h3,
    32'h7FFFFFFF, 32'h0, 32'h0, 32'h80000000, 32'h00010008};
  localparam logic [31:0] T_STAT [NV] = '{32'h1, 32'h000100FB, 32'h000100F8,
    32'h000100FB, 32'h0, 32'h00010008, 32'h00010008, 32'h00010008, 32'h40};
  localparam logic        T_ERR  [NV] = '{1'b0, 1'b1, 1'b0, 1'b0, 1'b0,
    1'b0, 1'b1, 1'b1, 1'b0};
  localparam string       T_REQ  [NV] = '{"R2", "R2", "R3", "R3", "R3",
    "R2", "R4", "R4", "R3"};

  logic             clk = 1'b0;
  logic             rst_n;
  logic [31:0]      post_vec, clr_vec, mask_wdata;
  logic             mask_we;
  logic [DLY_W-1:0] delay_cfg;
  logic [31:0]      status_o;
  logic             irq_o, rsvd_err_o;

  int n_run = 0;
  int n_bad = 0;

  always #2.5 clk = ~clk;

  irq_coalesce_top #(.DLY_W(DLY_W)) dut_i (
    .clk(clk), .rst_n(rst_n), .post_vec(post_vec), .clr_vec(clr_vec),
    .mask_we(mask_we), .mask_wdata(mask_wdata), .delay_cfg(delay_cfg),
    .status_o(status_o), .irq_o(irq_o), .rsvd_err_o(rsvd_err_o)
  );

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic pulse(logic [31:0] p, logic [31:0] c);
    post_vec = p; clr_vec = c;
    tick();
    post_vec = '0; clr_vec = '0;
  endtask

  task automatic set_mask(logic [31:0] m);
    mask_we = 1'b1; mask_wdata = m;
    tick();
    mask_we = 1'b0;
  endtask

  initial begin
    #1_000_000;
    n_bad++;
    $display("FAIL watchdog act=hung exp=done");
    $display("[TB] %0d tests run, %0d failed", n_run, n_bad);
    $finish;
  end

  initial begin
    rst_n = 1'b0; post_vec = '0; clr_vec = '0; mask_we = 1'b0;
    mask_wdata = '0; delay_cfg = 16'd10;
    @(negedge clk);
    tick(); tick();
    chk("R1 status", status_o, 32'h0);
    chk("R1 irq", {31'h0, irq_o}, 32'h0);
    chk("R1 err", {31'h0, rsvd_err_o}, 32'h0);
    rst_n = 1'b1;
    tick();

    // table walk, mask 0
    for (int i = 0; i < NV; i++) begin
      pulse(T_POST[i], T_CLR[i]);
      chk(T_REQ[i], status_o, T_STAT[i]);
      chk("R5 err", {31'h0, rsvd_err_o}, {31'h0, T_ERR[i]});
      chk("R6 masked", {31'h0, irq_o}, 32'h0);
    end
    tick();
    chk("R5 err low", {31'h0, rsvd_err_o}, 32'h0);
    chk("R6 masked idle", {31'h0, irq_o}, 32'h0);
    pulse(32'h0, 32'h7FFFFFFF);

    // enable only bit 0, post software cause: stays quiet
    set_mask(32'h1);
    pulse(32'h8, 32'h0);
    repeat (15) tick();
    chk("R6 disabled cause", {31'h0, irq_o}, 32'h0);
    pulse(32'h0, 32'h8);
    set_mask(32'hFFFFFFFF);

    // urgent: two edges after post
    pulse(32'h8, 32'h0);
    chk("R7 not yet", {31'h0, irq_o}, 32'h0);
    tick();
    chk("R7 urgent", {31'h0, irq_o}, 32'h1);
    pulse(32'h1, 32'h0);
    chk("R10 hold", {31'h0, irq_o}, 32'h1);
    pulse(32'h0, 32'h9);
    chk("R11 still", {31'h0, irq_o}, 32'h1);
    tick();
    chk("R11 drop", {31'h0, irq_o}, 32'h0);

    // aborted delayable count, then fresh full delay
    pulse(32'h1, 32'h0);
    repeat (3) tick();
    pulse(32'h0, 32'h1);
    tick();
    chk("R11 abort", {31'h0, irq_o}, 32'h0);
    pulse(32'h2, 32'h0);
    repeat (10) tick();
    chk("R8 early", {31'h0, irq_o}, 32'h0);
    tick();
    chk("R8 delayed", {31'h0, irq_o}, 32'h1);
    pulse(32'h0, 32'h2);
    tick();

    // urgent during running count
    pulse(32'h40, 32'h0);
    tick(); tick();
    pulse(32'h10, 32'h0);
    chk("R9 wait", {31'h0, irq_o}, 32'h0);
    tick();
    chk("R9 cancel", {31'h0, irq_o}, 32'h1);

    // drop by masking, restore
    set_mask(32'h0);
    tick();
    chk("R11 mask drop", {31'h0, irq_o}, 32'h0);
    chk("R11 status kept", status_o, 32'h50);
    set_mask(32'hFFFFFFFF);
    tick();
    chk("R7 remask", {31'h0, irq_o}, 32'h1);
    pulse(32'h0, 32'h50);
    tick();

    // zero delay behaves like urgent
    delay_cfg = '0;
    pulse(32'h80, 32'h0);
    chk("R8 zero wait", {31'h0, irq_o}, 32'h0);
    tick();
    chk("R8 zero delay", {31'h0, irq_o}, 32'h1);

    // reset mid-run
    rst_n = 1'b0;
    tick();
    chk("R1 mid status", status_o, 32'h0);
    chk("R1 mid irq", {31'h0, irq_o}, 32'h0);
    rst_n = 1'b1;
    pulse(32'h8, 32'h0);
    tick(); tick();
    chk("R1 mask cleared", {31'h0, irq_o}, 32'h0);

    $display("[TB] %0d tests run, %0d failed", n_run, n_bad);
    $finish;
  end
endmodule